// File: doc/BRIEF.md
# SPI Master Block-Transfer Controller

This block is a register-mapped SPI master that moves a programmed number of bytes between a slave device and a 32-bit data FIFO port. Software chooses a clock-rate code, a direction and a byte count, and then sets a go bit. In the write direction the block drains bytes from words that software pushed into the FIFO. In the read direction it packs received bytes into words that software pops from the same FIFO.

Chip select is held by a separate select register. A transfer drives chip select low, and chip select stays low after the count is done. It rises only when software clears the select register, so one chip-select window can span several block transfers, for example a command write followed by a data read. The shifter stops when it has no data to send or no room to store what it receives, so no byte is ever lost or made up.

Top module: `spi_blk_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the control, length and select registers read 0, the status register reads 0 and the FIFO is empty.
- R2: A control write at word address 0 with bit 15 set, while idle and with a nonzero length, starts a transfer. Control bit 15 then reads 1, the select register (address 3, bit 0) reads 1 and chip select goes low. Control bits 2:0 (rate), 12 (bus mode, stored only) and 13 (1 = write to slave, 0 = read from slave) read back as written.
- R3: The serial clock idles low, has a period of 2^(rate+1) system clocks, and carries each byte MSB first. Data out changes only while the serial clock is low, and data in is sampled on its rising edge.
- R4: In write mode, bytes are taken from each FIFO word lowest byte first (bits 7:0 first). The unused upper bytes of a final partial word are discarded, and exactly 8 × length clock pulses are produced.
- R5: In read mode, received bytes are packed into words lowest byte first. A final partial word has zero upper bytes. Reading the data register (address 2) while the FIFO is empty returns 0.
- R6: When the count has been moved, control bit 15 clears, a single-cycle finished pulse is produced on `xfer_done`, and chip select stays low.
- R7: Writing 0 to the select register while idle raises chip select and clears the register. The same write while a transfer is busy has no effect.
- R8: In write mode, when the FIFO is empty at a word boundary, the shifter waits with the clock low and resumes when a word is pushed.
- R9: In read mode, when the FIFO is full and a word is complete, the shifter waits. No received byte is lost, and the transfer finishes once software makes room.
- R10: Status register (address 4) bit 0 and the `fifo_full` pin read 1 exactly when the FIFO holds its depth in words (8 by default).
- R11: A start with a length (address 1) of 0 moves no data, leaves chip select high and gives no finished pulse. While busy, writes to the control and length registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the FIFO at address 2) |
| reg_rdata | output | 32 | Register read data, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |
| fifo_full | output | 1 | FIFO holds its full depth |
| xfer_done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
On every cycle, the checker enforces the serial-clock discipline: the clock stays low while deselected, and data out holds steady through each high phase. It also checks that the finished pulse lasts one cycle and comes while chip select is still low, that busy implies chip select is low, and that the FIFO fill level never goes past its depth. Only the bench scenarios can show the byte ordering within words, the zero padding, the exact clock period at each rate, and the stalls on an empty or full FIFO with the data still intact afterwards. The same goes for register writes that are ignored while busy.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;
   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_FETCH = 2'd1,
      SH_BITS  = 2'd2
   } sh_state_t;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_LEN  = 3'd1;
   localparam logic [2:0] A_DATA = 3'd2;
   localparam logic [2:0] A_SEL  = 3'd3;
   localparam logic [2:0] A_STAT = 3'd4;

   localparam int CB_GO   = 15;
   localparam int CB_DIR  = 13;
   localparam int CB_MODE = 12;
endpackage

// File: rtl/spi_blk_fifo.sv
module spi_blk_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [W-1:0]             wdata,
   input  logic                     pop,
   output logic [W-1:0]             rdata,
   output logic                     full,
   output logic                     empty,
   output logic [$clog2(DEPTH):0]   level
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic         do_push, do_pop;

   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign empty   = (wp == rp);
   assign level   = wp - rp;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/spi_blk_clkdiv.sv
module spi_blk_clkdiv #(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int CW = (1 << RATE_W) - 1;

   logic [CW-1:0] cnt, lim;

   assign lim  = (CW'(1) << rate) - CW'(1);
   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_blk_shifter.sv
module spi_blk_shifter
   import spi_blk_pkg::*;
#(
   parameter int RATE_W = 3,
   parameter int CNT_W  = 32,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic [CNT_W-1:0]  len_i,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_empty,
   output logic              tx_pop,
   input  logic              rx_full,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy
);
   localparam int BPW = WORD_W / 8;
   localparam int BIW = (BPW > 1) ? $clog2(BPW) : 1;

   sh_state_t         st;
   logic [CNT_W-1:0]  remain;
   logic [BIW-1:0]    bidx;
   logic [7:0]        shreg, rxsh;
   logic [WORD_W-1:0] wbuf, asmw;
   logic              pend, sclk_q, dir_q, tick, push_ok, byte_end;
   logic [2:0]        bitcnt;
   logic [RATE_W-1:0] rate_q;

   spi_blk_clkdiv #(.RATE_W(RATE_W)) div_i (
      .clk(clk), .rst_n(rst_n), .run(st == SH_BITS), .rate(rate_q), .tick(tick)
   );

   assign push_ok  = pend && !rx_full;
   assign rx_push  = push_ok;
   assign rx_word  = asmw;
   assign tx_pop   = (st == SH_FETCH) && dir_q && (bidx == '0) && !tx_empty;
   assign busy     = (st != SH_IDLE) || pend;
   assign sclk     = sclk_q;
   assign mosi     = (st == SH_BITS) && shreg[7];
   assign byte_end = (st == SH_BITS) && tick && sclk_q && (bitcnt == 3'd7);

   // received bytes land in their lane, lowest lane first
   for (genvar g = 0; g < BPW; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       lane_q <= '0;
         else if (push_ok)                                 lane_q <= '0;
         else if (byte_end && !dir_q && bidx == BIW'(g))   lane_q <= rxsh;
      end
      assign asmw[g*8 +: 8] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SH_IDLE;
         remain <= '0;
         bidx   <= '0;
         shreg  <= '0;
         rxsh   <= '0;
         wbuf   <= '0;
         pend   <= 1'b0;
         bitcnt <= '0;
         sclk_q <= 1'b0;
         dir_q  <= 1'b0;
         rate_q <= '0;
      end else begin
         if (push_ok) pend <= 1'b0;
         case (st)
            SH_IDLE: if (start) begin
               st     <= SH_FETCH;
               remain <= len_i;
               bidx   <= '0;
               bitcnt <= '0;
               dir_q  <= dir_i;
               rate_q <= rate_i;
            end
            SH_FETCH: begin
               if (dir_q) begin
                  if (bidx == '0) begin
                     if (!tx_empty) begin
                        wbuf  <= tx_word;
                        shreg <= tx_word[7:0];
                        st    <= SH_BITS;
                     end
                  end else begin
                     shreg <= wbuf[bidx*8 +: 8];
                     st    <= SH_BITS;
                  end
               end else if (!pend) begin
                  shreg <= '0;
                  st    <= SH_BITS;
               end
            end
            SH_BITS: if (tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rxsh   <= {rxsh[6:0], miso};
               end else begin
                  sclk_q <= 1'b0;
                  shreg  <= {shreg[6:0], 1'b0};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     bidx   <= bidx + 1'b1;
                     remain <= remain - 1'b1;
                     if (!dir_q && (bidx == BIW'(BPW-1) || remain == CNT_W'(1)))
                        pend <= 1'b1;
                     st <= (remain == CNT_W'(1)) ? SH_IDLE : SH_FETCH;
                  end
               end
            end
            default: st <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_blk_ctrl.sv
module spi_blk_ctrl
   import spi_blk_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int RATE_W     = 3,
   parameter int CNT_W      = 32,
   parameter int ADDR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [31:0]       reg_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n,
   output logic              fifo_full,
   output logic              xfer_done
);
   localparam int DW = 32;
   localparam int LW = $clog2(FIFO_DEPTH) + 1;

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (RATE_W < 1 || RATE_W > 4) begin : g_bad_rate
      $error("RATE_W must lie in 1..4");
   end
   if (CNT_W < 1 || CNT_W > 32 || ADDR_W < 3) begin : g_bad_width
      $error("CNT_W must lie in 1..32 and ADDR_W be at least 3");
   end

   logic [RATE_W-1:0] rate_r;
   logic              mode_r, dir_r, sel_r, busy_q;
   logic [CNT_W-1:0]  len_r;
   logic              sh_busy, sh_pop, sh_push, start;
   logic [DW-1:0]     sh_word, f_rdata, f_wdata;
   logic              f_full, f_empty, f_push, f_pop, cpu_push, cpu_pop;
   logic              wr_ctrl, wr_len, wr_sel;
   logic [LW-1:0]     f_level;

   assign wr_ctrl  = reg_wr && reg_addr == ADDR_W'(A_CTRL) && !sh_busy;
   assign wr_len   = reg_wr && reg_addr == ADDR_W'(A_LEN)  && !sh_busy;
   assign wr_sel   = reg_wr && reg_addr == ADDR_W'(A_SEL)  && !sh_busy;
   assign start    = wr_ctrl && reg_wdata[CB_GO] && (len_r != '0);
   assign cpu_push = reg_wr && reg_addr == ADDR_W'(A_DATA) && !(sh_busy && !dir_r);
   assign cpu_pop  = reg_rd && reg_addr == ADDR_W'(A_DATA) && !(sh_busy && dir_r);
   assign f_push   = cpu_push || sh_push;
   assign f_pop    = cpu_pop || sh_pop;
   assign f_wdata  = sh_push ? sh_word : reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_r <= '0;
         mode_r <= 1'b0;
         dir_r  <= 1'b0;
         len_r  <= '0;
         sel_r  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= sh_busy;
         if (wr_ctrl) begin
            rate_r <= reg_wdata[RATE_W-1:0];
            mode_r <= reg_wdata[CB_MODE];
            dir_r  <= reg_wdata[CB_DIR];
         end
         if (wr_len) len_r <= reg_wdata[CNT_W-1:0];
         if (start) sel_r <= 1'b1;
         else if (wr_sel && !reg_wdata[0]) sel_r <= 1'b0;
      end
   end

   spi_blk_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(f_push), .wdata(f_wdata), .pop(f_pop),
      .rdata(f_rdata), .full(f_full), .empty(f_empty), .level(f_level)
   );

   spi_blk_shifter #(.RATE_W(RATE_W), .CNT_W(CNT_W), .WORD_W(DW)) sh_i (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_i(reg_wdata[CB_DIR]),
      .rate_i(reg_wdata[RATE_W-1:0]), .len_i(len_r),
      .tx_word(f_rdata), .tx_empty(f_empty), .tx_pop(sh_pop),
      .rx_full(f_full), .rx_push(sh_push), .rx_word(sh_word),
      .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL): begin
            reg_rdata[RATE_W-1:0] = rate_r;
            reg_rdata[CB_MODE]    = mode_r;
            reg_rdata[CB_DIR]     = dir_r;
            reg_rdata[CB_GO]      = sh_busy;
         end
         ADDR_W'(A_LEN):  reg_rdata[CNT_W-1:0] = len_r;
         ADDR_W'(A_DATA): reg_rdata = f_empty ? '0 : f_rdata;
         ADDR_W'(A_SEL):  reg_rdata[0] = sel_r;
         ADDR_W'(A_STAT): reg_rdata[0] = f_full;
         default:         reg_rdata = '0;
      endcase
   end

   assign spi_cs_n  = !sel_r;
   assign fifo_full = f_full;
   assign xfer_done = busy_q && !sh_busy;
endmodule

// File: rtl/spi_blk_ctrl_chk.sv
module spi_blk_ctrl_chk #(
   parameter int FIFO_DEPTH = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        sclk,
   input logic                        mosi,
   input logic                        cs_n,
   input logic                        done,
   input logic                        busy,
   input logic [$clog2(FIFO_DEPTH):0] level
);
   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_cs_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cs_n);

   p_busy_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n);

   p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      level <= ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH));
endmodule

bind spi_blk_ctrl spi_blk_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
   .done(xfer_done), .busy(sh_busy), .level(f_level)
);

// File: tb/spi_blk_ctrl_tb_top.sv
module spi_blk_ctrl_tb_top;
   localparam int HALF = 10;   // 20-unit period: 50 MHz with 1 ns units
   localparam logic [2:0] A_CTRL = 3'd0, A_LEN = 3'd1, A_DATA = 3'd2,
                          A_SEL = 3'd3, A_STAT = 3'd4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic spi_sclk, spi_mosi, spi_miso, spi_cs_n, fifo_full, xfer_done;

   int n_chk = 0, n_bad = 0, done_cnt = 0, rises = 0, mbase = 0;
   bit cap [4096];
   longint last_t = 0, per = 0;

   always #HALF clk = ~clk;

   spi_blk_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n), .fifo_full(fifo_full), .xfer_done(xfer_done)
   );

   function automatic logic [7:0] txb(int i, int s);
      return 8'(i * 53 + 7 + s);
   endfunction
   function automatic logic [7:0] rxb(int i);
      return 8'(i * 29 + 11);
   endfunction
   function automatic logic miso_bit(int i);
      logic [7:0] v;
      v = rxb(i / 8);
      return v[7 - (i % 8)];
   endfunction

   assign spi_miso = miso_bit(rises - mbase);

   always @(posedge spi_sclk) begin
      cap[rises % 4096] = spi_mosi;
      per    = $time - last_t;
      last_t = $time;
      rises  = rises + 1;
   end
   always @(posedge clk) if (xfer_done) done_cnt <= done_cnt + 1;

   task automatic check_eq(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask
   task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask
   task automatic wait_idle();
      logic [31:0] d;
      for (int t = 0; t < 20000; t++) begin
         bus_rd(A_CTRL, d);
         if (!d[15]) break;
      end
   endtask
   task automatic release_cs(string req);
      bus_wr(A_SEL, 32'h0);
      @(negedge clk);
      check_eq({req, " cs released"}, spi_cs_n, 1);
   endtask

   // R4 R6 R7: write a block and compare captured MOSI bytes
   task automatic run_wr(int len, int rate, int s);
      int base, bad = 0, d0 = done_cnt;
      logic [31:0] w;
      logic [7:0] got;
      for (int wi = 0; wi < (len + 3) / 4; wi++) begin
         for (int b = 0; b < 4; b++)
            w[b*8 +: 8] = (wi*4 + b < len) ? txb(wi*4 + b, s) : 8'hEE;
         bus_wr(A_DATA, w);
      end
      base = rises;
      bus_wr(A_LEN, len);
      bus_wr(A_CTRL, 32'h0000_A000 | rate);
      wait_idle();
      for (int k = 0; k < len; k++) begin
         for (int j = 0; j < 8; j++) got[7-j] = cap[(base + k*8 + j) % 4096];
         if (got != txb(k, s)) bad++;
      end
      check_eq("R4 write bytes wrong", bad, 0);
      check_eq("R4 clock pulse count", rises - base, len * 8);
      check_eq("R6 one finished pulse", done_cnt - d0, 1);
      check_eq("R6 cs held low", spi_cs_n, 0);
      release_cs("R7");
   endtask

   // R5 R6: read a block and compare packed words
   task automatic run_rd(int len, int rate);
      int d0 = done_cnt;
      logic [31:0] w, e;
      mbase = rises;
      bus_wr(A_LEN, len);
      bus_wr(A_CTRL, 32'h0000_8000 | rate);
      wait_idle();
      for (int wi = 0; wi < (len + 3) / 4; wi++) begin
         for (int b = 0; b < 4; b++)
            e[b*8 +: 8] = (wi*4 + b < len) ? rxb(wi*4 + b) : 8'h00;
         bus_rd(A_DATA, w);
         check_eq("R5 read word", w, e);
      end
      check_eq("R6 read finished pulse", done_cnt - d0, 1);
      release_cs("R7");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int base, d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_eq("R1 cs_n", spi_cs_n, 1);
      check_eq("R1 sclk", spi_sclk, 0);
      bus_rd(A_CTRL, d); check_eq("R1 ctrl", d, 0);
      bus_rd(A_LEN, d);  check_eq("R1 len", d, 0);
      bus_rd(A_SEL, d);  check_eq("R1 sel", d, 0);
      bus_rd(A_STAT, d); check_eq("R1 status", d, 0);
      bus_rd(A_DATA, d); check_eq("R5 empty data read", d, 0);

      // R2 control readback without start
      bus_wr(A_CTRL, 32'h0000_3005);
      bus_rd(A_CTRL, d); check_eq("R2 ctrl readback", d, 32'h3005);

      // R11 zero length start ignored
      d0 = done_cnt;
      bus_wr(A_LEN, 0);
      bus_wr(A_CTRL, 32'h0000_A000);
      repeat (20) @(negedge clk);
      check_eq("R11 zero length cs", spi_cs_n, 1);
      bus_rd(A_CTRL, d); check_eq("R11 zero length busy", d[15], 0);
      check_eq("R11 zero length pulse", done_cnt - d0, 0);

      // R3 period sweep over all rates, R2 busy and select while running
      for (int r = 0; r < 8; r++) begin
         bus_wr(A_DATA, 32'h0000_00A5 + r);
         bus_wr(A_LEN, 1);
         bus_wr(A_CTRL, 32'h0000_A000 | r);
         if (r == 3) begin
            bus_rd(A_CTRL, d); check_eq("R2 busy bit", d[15], 1);
            bus_rd(A_SEL, d);  check_eq("R2 select bit", d, 1);
            check_eq("R2 cs low", spi_cs_n, 0);
         end
         wait_idle();
         check_eq("R3 sclk period", per, (2 << r) * 2 * HALF);
         release_cs("R7");
      end

      // R4 write lengths sweep, two rates
      for (int l = 1; l <= 9; l++) run_wr(l, l % 2, l);
      // R5 read lengths sweep
      for (int l = 1; l <= 9; l++) run_rd(l, l % 3);

      // R8 write stall on empty FIFO
      begin
         int bad = 0;
         logic [7:0] got;
         bus_wr(A_DATA, {txb(3,0), txb(2,0), txb(1,0), txb(0,0)});
         base = rises;
         bus_wr(A_LEN, 8);
         bus_wr(A_CTRL, 32'h0000_A000);
         repeat (300) @(negedge clk);
         check_eq("R8 pulses before stall", rises - base, 32);
         check_eq("R8 clock low in stall", spi_sclk, 0);
         bus_rd(A_CTRL, d); check_eq("R8 still busy", d[15], 1);
         // R11 writes while busy are ignored
         bus_wr(A_CTRL, 32'h0000_8007);
         bus_wr(A_LEN, 99);
         bus_wr(A_SEL, 0);
         check_eq("R7 select write ignored while busy", spi_cs_n, 0);
         bus_wr(A_DATA, {txb(7,0), txb(6,0), txb(5,0), txb(4,0)});
         wait_idle();
         for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 8; j++) got[7-j] = cap[(base + k*8 + j) % 4096];
            if (got != txb(k, 0)) bad++;
         end
         check_eq("R8 bytes after resume", bad, 0);
         bus_rd(A_CTRL, d); check_eq("R11 ctrl unchanged", d, 32'h2000);
         bus_rd(A_LEN, d);  check_eq("R11 len unchanged", d, 8);
         release_cs("R7");
      end

      // R9 R10 read stall on full FIFO
      d0 = done_cnt;
      mbase = rises;
      bus_wr(A_LEN, 40);
      bus_wr(A_CTRL, 32'h0000_8000);
      repeat (1500) @(negedge clk);
      check_eq("R10 full pin", fifo_full, 1);
      bus_rd(A_STAT, d); check_eq("R10 status full", d, 1);
      check_eq("R9 pulses before stall", rises - mbase, 288);
      bus_rd(A_CTRL, d); check_eq("R9 still busy", d[15], 1);
      for (int wi = 0; wi < 10; wi++) begin
         logic [31:0] e;
         if (wi == 8) wait_idle();
         for (int b = 0; b < 4; b++) e[b*8 +: 8] = rxb(wi*4 + b);
         bus_rd(A_DATA, d);
         check_eq("R9 word after stall", d, e);
      end
      check_eq("R9 finished pulse", done_cnt - d0, 1);
      bus_rd(A_STAT, d); check_eq("R10 status not full", d, 0);
      release_cs("R7");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule